// File: doc/BRIEF.md
# Display PHY Power Sequencer

This block brings a four-lane serial display PHY up and takes it back down without software involvement. It reaches the PHY only through a small byte-wide register bus. Every update is a masked read-modify-write, so bits that a step does not own keep their value. A power-up request runs a fixed list of thirteen updates. The list clears the reference power-down, starts the work mode and loads the PLL dividers. It then powers the PLL and LDO, enables the clock lane and the requested data lanes, and applies two timed reset pulses. A power-down request runs a shorter list of four updates in a different order. The sequencer raises a done flag once the last write of a list has been accepted.

Register addresses combine a 3-bit part selector with a 5-bit offset to form an 8-bit index. The bus carries that index as a byte address, four bytes apart. The bus request side follows valid/ready. The sequencer raises `bus_valid` and holds the address, the direction and the write data until `bus_ready` is seen high at a clock edge. Only one transaction is in flight at a time. Read data is taken from `bus_rdata` in the cycle of a read handshake. Lane count and divider inputs are captured when a request is accepted.

Top module: `dphy_pwr_seq`

## Requirements
- R1: The bus byte address is `{part[2:0], offset[4:0], 2'b00}`, where part code 0 is analog, 1 is digital, 2 is the clock lane and 3..6 are data lanes 0..3. The digital reset register (part 1, offset 0) therefore appears at byte address 0x080.
- R2: Each update is a read of a register followed at once by a write to the same address. The written value is `(old & ~mask) | (value & mask)`, so bits outside the mask are preserved.
- R3: At most one bus transaction is outstanding. While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_we` and `bus_wdata` stay stable. `bus_valid` is low whenever `busy` is low.
- R4: Power-up writes go to register indices in this order: 0x00, 0x00, 0x03, 0x03, 0x04, 0x08, 0x0B, 0x01, 0x00, 0x01, 0x01, 0x20, 0x20.
- R5: After power-up, the PLL fields hold these values. Analog 0x03 bits 4:0 hold the pre-divider and bit 5 holds feedback-divider bit 8. Analog 0x04 holds feedback-divider bits 7:0. Analog 0x08 bit 5 is 1, analog 0x0B bits 3:0 are 0xF, and analog 0x01 bits 1:0 are 00.
- R6: The lane field is analog 0x00 bits 6:2. Bit 6 (clock lane) is always set. A lane count of 1, 2 or 3 sets that many data-lane bits from bit 2 upward. Any other count (0, 4..7) sets all four.
- R7: After power-up, analog 0x00 bit 7 (reference power-down) is 0 and bits 1:0 (work mode) are 01.
- R8: The sync reset sets analog 0x01 bit 2 and later clears it. The digital reset clears digital 0x00 bit 0 and later sets it. In each pulse, at least WAIT_CYCLES clock cycles separate the two writes.
- R9: Power-down writes indices 0x00, 0x01, 0x00, 0x00 in that order. It leaves analog 0x00 equal to 0x82 and analog 0x01 bits 1:0 equal to 11, with analog 0x01 bits 7:2 preserved.
- R10: `busy` and `done` are low after reset. An accepted request sets `busy` and clears `done`. `done` rises, and `busy` falls, just after the handshake of the last write of the list. `done` then stays high.
- R11: A request that arrives while `busy` is high has no effect on the bus or the registers. This includes a request in the cycle of the final write handshake. When both requests are high together in idle, power-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_req | input | 1 | Start the power-up list (sampled while idle) |
| pwr_dn_req | input | 1 | Start the power-down list (sampled while idle) |
| lane_cnt | input | 3 | Number of data lanes to enable |
| pll_prediv | input | 5 | PLL pre-divider value |
| pll_fbdiv | input | 9 | PLL feedback-divider value |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 10 | Byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid at a read handshake |
| busy | output | 1 | A list is running |
| done | output | 1 | The last list has finished |

## Verification
Two events can fall on the same clock edge: the end of a list and the arrival of a new power request. The bench watches the bus from its register model. It asserts the opposite request exactly in the cycle where the final write of a power-down list is being accepted. It then requires that `done` rises, that no further transaction appears and that the registers keep their power-down values. A second case raises both requests in the same idle cycle and judges that the power-up order is the one written. Back-pressure runs are also part of the bench, in which `bus_ready` drops every third cycle. They show that each write still matches its preceding read and that the reset pulse gaps hold under stalls.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int PART_W     = 3;
  localparam int OFF_W      = 5;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = PART_W + OFF_W;
  localparam int ADDR_W     = IDX_W + 2;
  localparam int STEP_W     = 5;
  localparam int DATA_LANES = 4;
  localparam int LANE_CNT_W = 3;
  localparam int PREDIV_W   = 5;
  localparam int FBDIV_W    = 9;

  typedef enum logic [PART_W-1:0] {
    PART_ANA = 3'd0,
    PART_DIG = 3'd1,
    PART_CLK = 3'd2,
    PART_L0  = 3'd3,
    PART_L1  = 3'd4,
    PART_L2  = 3'd5,
    PART_L3  = 3'd6
  } part_e;

  typedef struct packed {
    part_e              part;
    logic [OFF_W-1:0]   off;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  val;
    logic               pause;
    logic               last;
  } step_t;

  localparam logic [STEP_W-1:0] UP_FIRST = 5'd0;
  localparam logic [STEP_W-1:0] DN_FIRST = 5'd13;
endpackage

// File: rtl/pwr_seq_steps.sv
module pwr_seq_steps
  import pwr_seq_pkg::*;
(
  input  logic [STEP_W-1:0]     step,
  input  logic [LANE_CNT_W-1:0] lane_cnt,
  input  logic [PREDIV_W-1:0]   prediv,
  input  logic [FBDIV_W-1:0]    fbdiv,
  output step_t                 entry
);
  logic [DATA_LANES-1:0] data_en;
  logic                  all_lanes;
  logic [DATA_W-1:0]     lane_val;

  assign all_lanes = (lane_cnt == '0) || (lane_cnt > LANE_CNT_W'(DATA_LANES - 1));

  for (genvar gi = 0; gi < DATA_LANES; gi++) begin : g_lane
    assign data_en[gi] = all_lanes || (lane_cnt > LANE_CNT_W'(gi));
  end

  assign lane_val = {1'b0, 1'b1, data_en, 2'b00};

  function automatic step_t mk(part_e p, logic [OFF_W-1:0] o, logic [DATA_W-1:0] m,
                               logic [DATA_W-1:0] v, logic ps, logic ls);
    step_t s;
    s.part  = p;
    s.off   = o;
    s.mask  = m;
    s.val   = v;
    s.pause = ps;
    s.last  = ls;
    return s;
  endfunction

  always_comb begin
    case (step)
      5'd0:    entry = mk(PART_ANA, 5'h00, 8'h80, 8'h00, 1'b0, 1'b0);
      5'd1:    entry = mk(PART_ANA, 5'h00, 8'h03, 8'h01, 1'b0, 1'b0);
      5'd2:    entry = mk(PART_ANA, 5'h03, 8'h1F, {3'b000, prediv}, 1'b0, 1'b0);
      5'd3:    entry = mk(PART_ANA, 5'h03, 8'h20, {2'b00, fbdiv[8], 5'b00000}, 1'b0, 1'b0);
      5'd4:    entry = mk(PART_ANA, 5'h04, 8'hFF, fbdiv[7:0], 1'b0, 1'b0);
      5'd5:    entry = mk(PART_ANA, 5'h08, 8'h20, 8'h20, 1'b0, 1'b0);
      5'd6:    entry = mk(PART_ANA, 5'h0B, 8'h0F, 8'h0F, 1'b0, 1'b0);
      5'd7:    entry = mk(PART_ANA, 5'h01, 8'h03, 8'h00, 1'b0, 1'b0);
      5'd8:    entry = mk(PART_ANA, 5'h00, 8'h7C, lane_val, 1'b0, 1'b0);
      5'd9:    entry = mk(PART_ANA, 5'h01, 8'h04, 8'h04, 1'b1, 1'b0);
      5'd10:   entry = mk(PART_ANA, 5'h01, 8'h04, 8'h00, 1'b0, 1'b0);
      5'd11:   entry = mk(PART_DIG, 5'h00, 8'h01, 8'h00, 1'b1, 1'b0);
      5'd12:   entry = mk(PART_DIG, 5'h00, 8'h01, 8'h01, 1'b0, 1'b1);
      5'd13:   entry = mk(PART_ANA, 5'h00, 8'h7C, 8'h00, 1'b0, 1'b0);
      5'd14:   entry = mk(PART_ANA, 5'h01, 8'h03, 8'h03, 1'b0, 1'b0);
      5'd15:   entry = mk(PART_ANA, 5'h00, 8'h03, 8'h02, 1'b0, 1'b0);
      5'd16:   entry = mk(PART_ANA, 5'h00, 8'h80, 8'h80, 1'b0, 1'b1);
      default: entry = mk(PART_ANA, 5'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    endcase
  end
endmodule

// File: rtl/pwr_seq_wait.sv
module pwr_seq_wait #(
  parameter int WAIT_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;

  assign expired = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= LOAD;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_rmw.sv
module pwr_seq_rmw
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              fin
);
  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_e;

  eng_e              st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] wdata_q;

  assign bus_valid = (st != E_IDLE);
  assign bus_we    = (st == E_WR);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign fin       = (st == E_WR) && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      val_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          addr_q <= addr_i;
          mask_q <= mask_i;
          val_q  <= val_i;
          st     <= E_RD;
        end
        E_RD: if (bus_ready) begin
          wdata_q <= (bus_rdata & ~mask_q) | (val_q & mask_q);
          st      <= E_WR;
        end
        E_WR: if (bus_ready) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dphy_pwr_seq.sv
module dphy_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int WAIT_CYCLES = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_up_req,
  input  logic                  pwr_dn_req,
  input  logic [LANE_CNT_W-1:0] lane_cnt,
  input  logic [PREDIV_W-1:0]   pll_prediv,
  input  logic [FBDIV_W-1:0]    pll_fbdiv,
  output logic                  bus_valid,
  input  logic                  bus_ready,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  busy,
  output logic                  done
);
  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_XFER, T_PAUSE} top_e;

  top_e                  st;
  logic [STEP_W-1:0]     step;
  logic [LANE_CNT_W-1:0] lanes_q;
  logic [PREDIV_W-1:0]   prediv_q;
  logic [FBDIV_W-1:0]    fbdiv_q;
  step_t                 cur;
  logic                  eng_start;
  logic                  eng_fin;
  logic                  dly_start;
  logic                  dly_exp;
  logic [ADDR_W-1:0]     cur_addr;

  pwr_seq_steps u_steps (
    .step     (step),
    .lane_cnt (lanes_q),
    .prediv   (prediv_q),
    .fbdiv    (fbdiv_q),
    .entry    (cur)
  );

  assign cur_addr  = {cur.part, cur.off, 2'b00};
  assign eng_start = (st == T_ISSUE);
  assign dly_start = (st == T_XFER) && eng_fin && cur.pause;
  assign busy      = (st != T_IDLE);

  pwr_seq_rmw u_rmw (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .addr_i    (cur_addr),
    .mask_i    (cur.mask),
    .val_i     (cur.val),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fin       (eng_fin)
  );

  pwr_seq_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (dly_start),
    .expired (dly_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      step     <= '0;
      lanes_q  <= '0;
      prediv_q <= '0;
      fbdiv_q  <= '0;
      done     <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (pwr_up_req || pwr_dn_req) begin
          step     <= pwr_up_req ? UP_FIRST : DN_FIRST;
          lanes_q  <= lane_cnt;
          prediv_q <= pll_prediv;
          fbdiv_q  <= pll_fbdiv;
          done     <= 1'b0;
          st       <= T_ISSUE;
        end
        T_ISSUE: st <= T_XFER;
        T_XFER: if (eng_fin) begin
          if (cur.pause) begin
            st <= T_PAUSE;
          end else if (cur.last) begin
            done <= 1'b1;
            st   <= T_IDLE;
          end else begin
            step <= step + 1'b1;
            st   <= T_ISSUE;
          end
        end
        T_PAUSE: if (dly_exp) begin
          step <= step + 1'b1;
          st   <= T_ISSUE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic       bus_we,
  input logic [9:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       busy,
  input logic       done
);
  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R3
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  // R2
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_we |=> bus_valid && bus_we && (bus_addr == $past(bus_addr)));

  // R1
  part_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[9:7] <= 3'd6) && (bus_addr[1:0] == 2'b00));

  // R10
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_valid && bus_ready && bus_we));
endmodule

bind dphy_pwr_seq pwr_seq_chk u_chk (.*);

// File: tb/dphy_pwr_seq_bench.sv
module dphy_pwr_seq_bench;
  localparam int W = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_up_req = 1'b0;
  logic       pwr_dn_req = 1'b0;
  logic [2:0] lane_cnt = '0;
  logic [4:0] pll_prediv = '0;
  logic [8:0] pll_fbdiv = '0;
  logic       bus_valid, bus_we, busy, done;
  logic       bus_ready = 1'b1;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  dphy_pwr_seq #(.WAIT_CYCLES(W)) u_dphy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
    .lane_cnt(lane_cnt), .pll_prediv(pll_prediv), .pll_fbdiv(pll_fbdiv),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done)
  );

  // register model of the PHY
  logic [7:0] mem [0:255];
  logic [7:0] snap [0:255];
  logic [7:0] widx [0:255];
  logic [7:0] wdat [0:255];
  logic [9:0] waddr [0:255];
  int         wtime [0:255];
  int         cyc = 0;
  int         wcnt = 0;
  bit         stall = 1'b0;

  assign bus_rdata = mem[bus_addr[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 59) ^ 8'hC6;
    end else if (bus_valid && bus_ready && bus_we) begin
      mem[bus_addr[9:2]]  <= bus_wdata;
      widx[wcnt[7:0]]     <= bus_addr[9:2];
      wdat[wcnt[7:0]]     <= bus_wdata;
      waddr[wcnt[7:0]]    <= bus_addr;
      wtime[wcnt[7:0]]    <= cyc;
      wcnt                <= wcnt + 1;
    end
  end

  always @(negedge clk) bus_ready <= stall ? ((cyc % 3) != 2) : 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam logic [7:0] UP_ORD [0:12] = '{8'h00, 8'h00, 8'h03, 8'h03, 8'h04, 8'h08,
                                           8'h0B, 8'h01, 8'h00, 8'h01, 8'h01, 8'h20, 8'h20};
  localparam logic [7:0] DN_ORD [0:3]  = '{8'h00, 8'h01, 8'h00, 8'h00};

  // {up, stall, lanes[2:0], prediv[4:0], fbdiv[8:0], expected lane field[4:0]}
  localparam int NV = 8;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 3'd1, 5'h03, 9'h1A5, 5'b10001},
    {1'b0, 1'b0, 3'd0, 5'h00, 9'h000, 5'b00000},
    {1'b1, 1'b1, 3'd2, 5'h1F, 9'h0FF, 5'b10011},
    {1'b1, 1'b0, 3'd3, 5'h01, 9'h100, 5'b10111},
    {1'b0, 1'b1, 3'd0, 5'h00, 9'h000, 5'b00000},
    {1'b1, 1'b1, 3'd0, 5'h0A, 9'h00C, 5'b11111},
    {1'b1, 1'b0, 3'd6, 5'h12, 9'h1FF, 5'b11111},
    {1'b0, 1'b0, 3'd4, 5'h00, 9'h000, 5'b00000}
  };

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!done) chk("R10 done timeout", 0, 1);
  endtask

  task automatic launch(input bit up, input bit dn, output int base);
    base = wcnt;
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    @(negedge clk);
    pwr_up_req = up;
    pwr_dn_req = dn;
    @(negedge clk);
    pwr_up_req = 1'b0;
    pwr_dn_req = 1'b0;
  endtask

  task automatic check_up(input int base, input logic [4:0] lanes_exp,
                          input logic [4:0] pre, input logic [8:0] fb);
    bit ord_ok = (wcnt - base) == 13;
    for (int i = 0; i < 13; i++) if (widx[8'(base + i)] != UP_ORD[i]) ord_ok = 1'b0;
    chk("R4 power-up order", 32'(ord_ok), 1);
    chk("R1 digital reg byte address", 32'(waddr[8'(base + 11)]), 32'h080);
    chk("R6 R7 analog 0x00", 32'(mem[8'h00]), 32'({1'b0, lanes_exp, 2'b01}));
    chk("R5 analog 0x01", 32'(mem[8'h01]), 32'({snap[8'h01][7:3], 3'b000}));
    chk("R5 R2 analog 0x03", 32'(mem[8'h03]), 32'({snap[8'h03][7:6], fb[8], pre}));
    chk("R5 analog 0x04", 32'(mem[8'h04]), 32'(fb[7:0]));
    chk("R5 R2 analog 0x08", 32'(mem[8'h08]), 32'(snap[8'h08] | 8'h20));
    chk("R5 R2 analog 0x0B", 32'(mem[8'h0B]), 32'({snap[8'h0B][7:4], 4'hF}));
    chk("R8 R2 digital 0x00", 32'(mem[8'h20]), 32'(snap[8'h20] | 8'h01));
    chk("R8 sync pulse", 32'(wdat[8'(base + 9)][2] && !wdat[8'(base + 10)][2] &&
        (wtime[8'(base + 10)] - wtime[8'(base + 9)] >= W)), 1);
    chk("R8 digital pulse", 32'(!wdat[8'(base + 11)][0] && wdat[8'(base + 12)][0] &&
        (wtime[8'(base + 12)] - wtime[8'(base + 11)] >= W)), 1);
  endtask

  task automatic check_dn(input int base);
    bit ord_ok = (wcnt - base) == 4;
    for (int i = 0; i < 4; i++) if (widx[8'(base + i)] != DN_ORD[i]) ord_ok = 1'b0;
    chk("R9 power-down order", 32'(ord_ok), 1);
    chk("R9 analog 0x00", 32'(mem[8'h00]), 32'h82);
    chk("R9 R2 analog 0x01", 32'(mem[8'h01]), 32'({snap[8'h01][7:2], 2'b11}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 32'(busy), 0);
    chk("R10 reset done", 32'(done), 0);
    chk("R3 reset bus idle", 32'(bus_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      stall      = VEC[v][22];
      lane_cnt   = VEC[v][21:19];
      pll_prediv = VEC[v][18:14];
      pll_fbdiv  = VEC[v][13:5];
      launch(VEC[v][23], !VEC[v][23], base);
      chk("R10 busy after accept", 32'({busy, done}), 32'b10);
      lane_cnt   = 3'd7;
      pll_prediv = 5'h00;
      pll_fbdiv  = 9'h000;
      wait_done();
      chk("R10 idle after list", 32'({busy, done}), 32'b01);
      if (VEC[v][23]) check_up(base, VEC[v][4:0], VEC[v][18:14], VEC[v][13:5]);
      else            check_dn(base);
    end

    // R11: request in the cycle of the final write handshake is ignored
    stall = 1'b0;
    launch(1'b0, 1'b1, base);
    begin
      int t = 0;
      while (!(bus_valid && bus_we && (wcnt - base) == 3) && t < 5000) begin
        @(negedge clk);
        t++;
      end
    end
    pwr_up_req = 1'b1;
    @(negedge clk);
    pwr_up_req = 1'b0;
    chk("R10 done on final write", 32'({busy, done}), 32'b01);
    repeat (10) @(negedge clk);
    chk("R11 late request ignored (writes)", 32'(wcnt - base), 4);
    chk("R11 late request ignored (reg)", 32'(mem[8'h00]), 32'h82);

    // R11: request in mid-sequence is ignored
    lane_cnt = 3'd2; pll_prediv = 5'h05; pll_fbdiv = 9'h0AA;
    launch(1'b1, 1'b0, base);
    repeat (8) @(negedge clk);
    pwr_dn_req = 1'b1;
    @(negedge clk);
    pwr_dn_req = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R11 mid request ignored (writes)", 32'(wcnt - base), 13);
    check_up(base, 5'b10011, 5'h05, 9'h0AA);

    // R11: both requests together, power-up wins
    launch(1'b0, 1'b1, base);
    wait_done();
    lane_cnt = 3'd3; pll_prediv = 5'h07; pll_fbdiv = 9'h033;
    launch(1'b1, 1'b1, base);
    wait_done();
    chk("R11 simultaneous picks up", 32'(wcnt - base), 13);
    check_up(base, 5'b10111, 5'h07, 9'h033);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule